// File: doc/BRIEF.md
# Prefixed Instruction Pairing FSM

This block sits between instruction fetch and decode in a small in-order core. Fetch hands it one 32-bit instruction word per transfer, together with that word's address. A word whose six most significant bits hold the vector-prefix opcode is not forwarded by itself. Instead, the block keeps the word's low 24-bit mode field in a private register, waits for the next word, and hands decode one packet. That packet carries the mode field and the following word, tagged with the address of the prefix. Any other word goes out alone with its prefixed flag clear and its mode field zero.

Interrupts must not split a prefix from its suffix. From the cycle in which a prefix is accepted until the cycle in which decode takes the combined packet, the block drives an inhibit line to the interrupt controller. Because a pair is restarted from its prefix, the packet's address is the prefix address. If a second prefix directly follows a prefix, the pair is still issued, but with an illegal-instruction flag set. A flush input discards any half-built pair or pending packet and drops the inhibit line in the same cycle.

Top module: `pfx_pair_fsm`

## Requirements
- R1: A word whose bits 31:26 equal 9 is a prefix. Accepting a prefix produces no output packet, and `out_valid` stays low until a suffix word is accepted.
- R2: `irq_inhibit` is high in the cycle in which a prefix is accepted. It stays high until the pair's packet is taken by `out_valid && out_ready`, and it is low from the following cycle.
- R3: One cycle after the suffix is accepted, `out_valid` is high with `out_prefixed` = 1, `out_mode` = bits 23:0 of the prefix and `out_word` = the suffix word.
- R4: The `out_addr` of a paired packet is the prefix word's address, never the suffix word's address.
- R5: A word that does not follow a prefix appears one cycle after it is accepted with `out_prefixed` = 0, `out_mode` = 0, `out_illegal` = 0 and its own word and address. `irq_inhibit` stays low throughout.
- R6: When the word after a prefix is itself a prefix, the pair is issued with `out_illegal` = 1, the first prefix's mode field and the first prefix's address.
- R7: `flush` forces `irq_inhibit`, `in_ready` and `out_valid` low in the same cycle. It drops any pending packet and discards a captured prefix, so the next accepted word is treated as unprefixed.
- R8: While a packet waits with `out_ready` low, `out_valid` stays high, the packet fields stay unchanged and `in_ready` is low.
- R9: After reset `out_valid` = 0, `irq_inhibit` = 0 and `in_ready` = 1.
- R10: `irq_inhibit` stays high across idle cycles between prefix and suffix, and across output stall cycles of a paired packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard pairing state and pending packet |
| in_valid | input | 1 | Fetch word available |
| in_ready | output | 1 | Block accepts a fetch word this cycle |
| in_word | input | 32 | Fetched instruction word |
| in_addr | input | 32 | Address of the fetched word |
| out_valid | output | 1 | Issue packet available |
| out_ready | input | 1 | Decode takes the packet this cycle |
| out_mode | output | 24 | Mode field of the prefix, zero for single words |
| out_word | output | 32 | Suffix word or single word |
| out_addr | output | 32 | Restart address of the packet |
| out_prefixed | output | 1 | Packet is a prefix/suffix pair |
| out_illegal | output | 1 | Suffix was itself a prefix |
| irq_inhibit | output | 1 | Interrupt acceptance blocked |

## Verification
The packet registers sit one clock edge behind the input handshake. Each packet field is therefore due at the first falling edge after the edge that accepted the word, and the bench samples it there. `irq_inhibit` is combinational on a prefix acceptance and on `flush`, so it is checked in the same half-cycle in which the stimulus is driven. Its release is checked at the falling edge after the consuming edge. The bench sweeps all 64 opcodes, both as single words and as suffixes, varying the number of idle cycles before the suffix and the number of stall cycles on the output, so that every hold window is sampled one cycle at a time.

// File: rtl/pfx_pair_pkg.sv
package pfx_pair_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_HAVE_PFX = 2'd1,
        ST_ISSUE    = 2'd2
    } pair_state_e;
endpackage

// File: rtl/pfx_word_class.sv
// Classifies a fetched word by its primary opcode and extracts the mode field.
module pfx_word_class #(
    parameter int WORD_W  = 32,
    parameter int MODE_W  = 24,
    parameter int OPC_W   = 6,
    parameter int PFX_OPC = 9
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_prefix,
    output logic [MODE_W-1:0] mode
);
    localparam int OPC_LSB = WORD_W - OPC_W;

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc       = word[WORD_W-1:OPC_LSB];
        is_prefix = (opc == OPC_W'(PFX_OPC));
        mode      = word[MODE_W-1:0];
    end
endmodule

// File: rtl/pair_irq_gate.sv
// Holds interrupt acceptance off from prefix acceptance until pair issue.
module pair_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic arm,
    input  logic release_pair,
    output logic irq_inhibit
);
    logic inh_d, inh_q;

    always_comb begin
        inh_d = inh_q;
        if (flush)             inh_d = 1'b0;
        else if (arm)          inh_d = 1'b1;
        else if (release_pair) inh_d = 1'b0;
        irq_inhibit = (inh_q | arm) & ~flush;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) inh_q <= 1'b0;
        else        inh_q <= inh_d;
    end

    assert_flush_drops_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !irq_inhibit);

    assert_arm_raises_inhibit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !flush) |=> (inh_q || flush));
endmodule

// File: rtl/pfx_pair_fsm.sv
module pfx_pair_fsm
    import pfx_pair_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int MODE_W  = 24,
    parameter int OPC_W   = 6,
    parameter int PFX_OPC = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [MODE_W-1:0] out_mode,
    output logic [WORD_W-1:0] out_word,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_prefixed,
    output logic              out_illegal,
    output logic              irq_inhibit
);
    typedef struct packed {
        pair_state_e       state;
        logic [MODE_W-1:0] pfx_mode;
        logic [ADDR_W-1:0] pfx_addr;
        logic [MODE_W-1:0] o_mode;
        logic [WORD_W-1:0] o_word;
        logic [ADDR_W-1:0] o_addr;
        logic              o_pfx;
        logic              o_ill;
    } pair_regs_t;

    pair_regs_t r_d, r_q;

    logic              word_is_pfx;
    logic [MODE_W-1:0] word_mode;
    logic              in_fire, out_fire, arm, release_pair;

    pfx_word_class #(
        .WORD_W (WORD_W),
        .MODE_W (MODE_W),
        .OPC_W  (OPC_W),
        .PFX_OPC(PFX_OPC)
    ) u_class (
        .word     (in_word),
        .is_prefix(word_is_pfx),
        .mode     (word_mode)
    );

    always_comb begin
        in_ready     = (r_q.state != ST_ISSUE) && !flush;
        out_valid    = (r_q.state == ST_ISSUE) && !flush;
        in_fire      = in_valid && in_ready;
        out_fire     = out_valid && out_ready;
        arm          = in_fire && word_is_pfx && (r_q.state == ST_IDLE);
        release_pair = out_fire && r_q.o_pfx;
        out_mode     = r_q.o_mode;
        out_word     = r_q.o_word;
        out_addr     = r_q.o_addr;
        out_prefixed = r_q.o_pfx;
        out_illegal  = r_q.o_ill;
    end

    always_comb begin
        r_d = r_q;
        if (flush) begin
            r_d.state    = ST_IDLE;
            r_d.pfx_mode = '0;
            r_d.pfx_addr = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (in_fire) begin
                        if (word_is_pfx) begin
                            r_d.pfx_mode = word_mode;
                            r_d.pfx_addr = in_addr;
                            r_d.state    = ST_HAVE_PFX;
                        end else begin
                            r_d.o_mode = '0;
                            r_d.o_word = in_word;
                            r_d.o_addr = in_addr;
                            r_d.o_pfx  = 1'b0;
                            r_d.o_ill  = 1'b0;
                            r_d.state  = ST_ISSUE;
                        end
                    end
                end
                ST_HAVE_PFX: begin
                    if (in_fire) begin
                        r_d.o_mode   = r_q.pfx_mode;
                        r_d.o_word   = in_word;
                        r_d.o_addr   = r_q.pfx_addr;
                        r_d.o_pfx    = 1'b1;
                        r_d.o_ill    = word_is_pfx;
                        r_d.pfx_mode = '0;
                        r_d.state    = ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (out_fire) r_d.state = ST_IDLE;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    pair_irq_gate u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .arm         (arm),
        .release_pair(release_pair),
        .irq_inhibit (irq_inhibit)
    );

    assert_inhibit_while_waiting_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HAVE_PFX && !flush) |-> irq_inhibit);

    assert_inhibit_on_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_prefixed) |-> irq_inhibit);

    assert_restart_at_prefix_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HAVE_PFX && in_fire) |=> (out_addr == $past(r_q.pfx_addr)));

    assert_single_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_prefixed) |-> (out_mode == '0 && !out_illegal));

    assert_hold_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (flush || (out_valid && $stable(out_word) && $stable(out_addr))));

    assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_flush_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (r_q.state == ST_IDLE));
endmodule

// File: tb/pfx_pair_fsm_tb.sv
`timescale 1ns/1ps
module pfx_pair_fsm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_mode;
    logic [31:0] out_word;
    logic [31:0] out_addr;
    logic        out_prefixed;
    logic        out_illegal;
    logic        irq_inhibit;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    pfx_pair_fsm dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_mode(out_mode),
        .out_word(out_word), .out_addr(out_addr), .out_prefixed(out_prefixed),
        .out_illegal(out_illegal), .irq_inhibit(irq_inhibit)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Called at a falling edge; a single unprefixed word.
    task automatic send_single(input logic [31:0] w, input logic [31:0] a);
        in_valid = 1'b1; in_word = w; in_addr = a;
        #0.1;
        chk("R5", "in_ready", in_ready, 1);
        chk("R5", "inhibit at accept", irq_inhibit, 0);
        step();
        in_valid = 1'b0;
        #0.1;
        chk("R5", "out_valid", out_valid, 1);
        chk("R5", "out_prefixed", out_prefixed, 0);
        chk("R5", "out_mode", out_mode, 0);
        chk("R5", "out_word", out_word, w);
        chk("R5", "out_addr", out_addr, a);
        chk("R5", "out_illegal", out_illegal, 0);
        chk("R5", "inhibit on single", irq_inhibit, 0);
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        #0.1;
        chk("R8", "out_valid after take", out_valid, 0);
    endtask

    task automatic send_pair(input logic [31:0] p, input logic [31:0] pa,
                             input logic [31:0] s, input logic [31:0] sa,
                             input int gap, input int stall);
        in_valid = 1'b1; in_word = p; in_addr = pa;
        #0.1;
        chk("R2", "inhibit at prefix accept", irq_inhibit, 1);
        chk("R1", "in_ready for prefix", in_ready, 1);
        step();
        in_valid = 1'b0;
        #0.1;
        chk("R1", "no packet after prefix", out_valid, 0);
        for (int g = 0; g < gap; g++) begin
            step();
            #0.1;
            chk("R10", "inhibit in gap", irq_inhibit, 1);
            chk("R1", "no packet in gap", out_valid, 0);
        end
        in_valid = 1'b1; in_word = s; in_addr = sa;
        #0.1;
        chk("R1", "in_ready for suffix", in_ready, 1);
        step();
        in_valid = 1'b0;
        #0.1;
        chk("R3", "out_valid", out_valid, 1);
        chk("R3", "out_prefixed", out_prefixed, 1);
        chk("R3", "out_mode", out_mode, p[23:0]);
        chk("R3", "out_word", out_word, s);
        chk("R4", "out_addr", out_addr, pa);
        chk("R6", "out_illegal", out_illegal, (s[31:26] == 6'd9));
        chk("R8", "in_ready while pending", in_ready, 0);
        chk("R2", "inhibit on pair", irq_inhibit, 1);
        for (int t = 0; t < stall; t++) begin
            step();
            #0.1;
            chk("R8", "held valid", out_valid, 1);
            chk("R8", "held word", out_word, s);
            chk("R10", "inhibit in stall", irq_inhibit, 1);
        end
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        #0.1;
        chk("R2", "inhibit released", irq_inhibit, 0);
        chk("R8", "out_valid after take", out_valid, 0);
    endtask

    initial begin
        #1000000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        chk("R9", "out_valid after reset", out_valid, 0);
        chk("R9", "inhibit after reset", irq_inhibit, 0);
        chk("R9", "in_ready after reset", in_ready, 1);

        // Every non-prefix opcode as a single word.
        for (int op = 0; op < 64; op++) begin
            if (op != 9) begin
                logic [25:0] low;
                low = 26'(op * 32'h9E37 ^ 32'h155);
                send_single({6'(op), low}, 32'h1000 + 32'(op) * 4);
            end
        end

        // Every opcode as a suffix, with varied gaps and stalls.
        for (int op = 0; op < 64; op++) begin
            logic [31:0] pw, sw, pa;
            pw = {6'd9, 26'(op * 32'h3C5A7 + 32'h2B)};
            sw = {6'(op), 26'(op * 32'h1F3 ^ 32'h3A5A5A)};
            pa = 32'h8000 + 32'(op) * 8;
            send_pair(pw, pa, sw, pa + 4, op % 3, op % 2);
        end

        // R7: flush with a captured prefix, then a plain word.
        in_valid = 1'b1; in_word = {6'd9, 26'h2AAAAAA}; in_addr = 32'h400;
        step();
        in_valid = 1'b0; flush = 1'b1;
        #0.1;
        chk("R7", "inhibit drops with flush", irq_inhibit, 0);
        chk("R7", "in_ready low in flush", in_ready, 0);
        step();
        flush = 1'b0;
        #0.1;
        chk("R7", "inhibit after flush", irq_inhibit, 0);
        send_single({6'd14, 26'h0123456}, 32'h404);

        // R7: flush drops a pending packet.
        in_valid = 1'b1; in_word = {6'd31, 26'h1111111}; in_addr = 32'h500;
        step();
        in_valid = 1'b0;
        #0.1;
        chk("R7", "packet pending", out_valid, 1);
        flush = 1'b1;
        #0.1;
        chk("R7", "out_valid low in flush", out_valid, 0);
        step();
        flush = 1'b0;
        #0.1;
        chk("R7", "packet dropped", out_valid, 0);

        // R7: prefix presented with flush is not taken.
        in_valid = 1'b1; in_word = {6'd9, 26'h3000001}; in_addr = 32'h600; flush = 1'b1;
        #0.1;
        chk("R7", "inhibit low with flushed prefix", irq_inhibit, 0);
        step();
        in_valid = 1'b0; flush = 1'b0;
        #0.1;
        chk("R7", "prefix not captured", irq_inhibit, 0);
        send_single({6'd2, 26'h0000042}, 32'h604);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule